// File: doc/BRIEF.md
# Signed bounds check trap unit

This block checks a signed 32-bit value against a range and tells the core whether to trap. It has two forms. The single-bound form tests the value against the range from zero up to an upper limit. The dual-bound form tests the value against a caller-supplied lower limit and upper limit. Each check rewrites only the condition flags it owns and passes the others through unchanged. A failed check raises a one-cycle trap request that carries exception number 6 and the program-counter advance the core applies before it takes the exception.

The core presents one operation at a time. It sets the form select, the value, both limits and its current five-bit flag word, and it pulses a valid strobe. One clock later the block returns the new flag word with a valid flag, the trap pulse, the vector and the PC advance. Fetching the operands, decoding the instruction and building the exception frame are left to the surrounding pipeline.

Top module: `bnd_trap_unit`

## Requirements
- R1: A strobe on `op_valid` at a rising edge produces results on the outputs right after that edge. `res_valid` is high for exactly those cycles.
- R2: Single-bound form (`op_sel`=0): the new N flag is 1 when the value is negative and 0 otherwise.
- R3: Single-bound form: when the upper limit is at least 0, C is 1 if the value is below 0 or above the upper limit. When the upper limit is negative, C is 1 only if the value lies above the upper limit and below 0.
- R4: Single-bound form: a trap is raised when the value is below 0 or above the upper limit, whatever the new C.
- R5: Dual-bound form (`op_sel`=1): the new Z flag is 1 when the value equals the lower limit or the upper limit, and 0 otherwise.
- R6: Dual-bound form: when lower <= upper, C is 1 if the value is below the lower limit or above the upper limit. When lower > upper, C is 1 only if the value lies above the upper limit and below the lower limit.
- R7: Dual-bound form: a trap is raised exactly when the new C is 1.
- R8: The flag word is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. Flags a form does not own are copied from `flags_in`. That means X, Z and V for the single-bound form, and X, N and V for the dual-bound form. All comparisons are two's-complement signed.
- R9: When `trap_req` is high, `trap_vec` is 6 and `pc_adv` is 2 for the single-bound form or 4 for the dual-bound form. When `trap_req` is low, both are 0.
- R10: In a cycle after an edge without `op_valid`, `trap_req` and `res_valid` are low and `flags_out` holds its previous value, whatever the operand inputs do.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Starts a check at this edge |
| op_sel | input | 1 | 0 = single-bound form, 1 = dual-bound form |
| val_in | input | 32 | Value under test, signed |
| lo_in | input | 32 | Lower limit, signed; unused by the single-bound form |
| hi_in | input | 32 | Upper limit, signed |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| flags_out | output | 5 | Updated flags {X,N,Z,V,C} |
| res_valid | output | 1 | Results belong to a check started at the last edge |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 8 | Exception number when trapping, else 0 |
| pc_adv | output | 3 | PC advance when trapping, else 0 |

## Verification
Values are placed just inside, exactly on, and just outside each limit, and also at the extreme negative and positive numbers. This separates an off-by-one in the comparators from a sign-handling mistake. Swapped limits are driven in both forms: a negative upper limit in the single form, and lower > upper in the dual form. These cases show whether the inverted C rule is used. They also show that in the single form the trap and C part ways. Idle cycles with changing operands and random flag words check that non-owned flags pass through and that held results do not move. A long random run over a small value range makes limit equalities common.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  localparam int BND_DW     = 32;
  localparam int NFLG       = 5;
  localparam int VEC_W      = 8;
  localparam int ADV_W      = 3;
  localparam int CHK_VEC    = 6;
  localparam int ADV_SINGLE = 2;
  localparam int ADV_DUAL   = 4;

  // flag word bit positions
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_X = 4;

  typedef enum logic {CHK_SINGLE = 1'b0, CHK_DUAL = 1'b1} chk_op_e;

  // comparison events against the effective limits
  typedef struct packed {
    logic below;    // value < lower limit (0 for single form)
    logic above;    // value > upper limit
    logic hit_lo;   // value == lower limit
    logic hit_hi;   // value == upper limit
    logic swapped;  // lower limit > upper limit
  } cmp_ev_t;

  // carry rule shared by both forms
  function automatic logic f_carry(input cmp_ev_t ev);
    return ev.swapped ? (ev.below & ev.above) : (ev.below | ev.above);
  endfunction

  function automatic logic [ADV_W-1:0] f_adv(input chk_op_e op);
    return (op == CHK_SINGLE) ? ADV_W'(ADV_SINGLE) : ADV_W'(ADV_DUAL);
  endfunction
endpackage

// File: rtl/bnd_cmp.sv
module bnd_cmp
  import bnd_pkg::*;
#(
  parameter int DW = BND_DW
) (
  input  chk_op_e         op,
  input  logic [DW-1:0]   val,
  input  logic [DW-1:0]   lo,
  input  logic [DW-1:0]   hi,
  output cmp_ev_t         ev
);
  logic [DW-1:0] lo_eff;

  // the single form is the dual form with an implicit lower limit of zero
  assign lo_eff = (op == CHK_SINGLE) ? '0 : lo;

  always_comb begin
    ev.below   = $signed(val) < $signed(lo_eff);
    ev.above   = $signed(val) > $signed(hi);
    ev.hit_lo  = (val == lo_eff);
    ev.hit_hi  = (val == hi);
    ev.swapped = $signed(lo_eff) > $signed(hi);
  end
endmodule

// File: rtl/bnd_flag_upd.sv
module bnd_flag_upd
  import bnd_pkg::*;
(
  input  chk_op_e          op,
  input  cmp_ev_t          ev,
  input  logic [NFLG-1:0]  flags_in,
  output logic [NFLG-1:0]  flags_nxt,
  output logic             trap,
  output logic [ADV_W-1:0] adv
);
  logic c_new;

  assign c_new = f_carry(ev);
  assign adv   = f_adv(op);

  always_comb begin
    flags_nxt        = flags_in;
    flags_nxt[FLG_C] = c_new;
    if (op == CHK_SINGLE) begin
      flags_nxt[FLG_N] = ev.below;          // below zero
      trap             = ev.below | ev.above;
    end else begin
      flags_nxt[FLG_Z] = ev.hit_lo | ev.hit_hi;
      trap             = c_new;
    end
  end
endmodule

// File: rtl/bnd_trap_unit.sv
module bnd_trap_unit
  import bnd_pkg::*;
#(
  parameter int DW = BND_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sel,
  input  logic [DW-1:0]    val_in,
  input  logic [DW-1:0]    lo_in,
  input  logic [DW-1:0]    hi_in,
  input  logic [NFLG-1:0]  flags_in,
  output logic [NFLG-1:0]  flags_out,
  output logic             res_valid,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec,
  output logic [ADV_W-1:0] pc_adv
);
  chk_op_e          op;
  cmp_ev_t          ev;
  logic [NFLG-1:0]  flags_nxt;
  logic             trap_nxt;
  logic [ADV_W-1:0] adv_nxt;

  assign op = chk_op_e'(op_sel);

  bnd_cmp #(.DW(DW)) u_cmp (
    .op  (op),
    .val (val_in),
    .lo  (lo_in),
    .hi  (hi_in),
    .ev  (ev)
  );

  bnd_flag_upd u_upd (
    .op        (op),
    .ev        (ev),
    .flags_in  (flags_in),
    .flags_nxt (flags_nxt),
    .trap      (trap_nxt),
    .adv       (adv_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_out <= '0;
      res_valid <= 1'b0;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      pc_adv    <= '0;
    end else begin
      res_valid <= op_valid;
      trap_req  <= op_valid & trap_nxt;
      trap_vec  <= (op_valid & trap_nxt) ? VEC_W'(CHK_VEC) : '0;
      pc_adv    <= (op_valid & trap_nxt) ? adv_nxt : '0;
      if (op_valid) flags_out <= flags_nxt;
    end
  end

  // R1: result valid follows the strobe by one cycle
  a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R10: idle cycles are quiet and hold the flags
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap_req && !res_valid && $stable(flags_out)));

  // R2: single form N mirrors the sign of the value
  a_r2_single_n: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 1'b0) |=> flags_out[FLG_N] == $past(val_in[DW-1]));

  // R4: a negative value always traps in the single form
  a_r4_neg_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 1'b0 && val_in[DW-1]) |=> trap_req);

  // R7: dual form trap agrees with the new C
  a_r7_dual_trap_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 1'b1) |=> trap_req == flags_out[FLG_C]);

  // R8: X and V are never written by either form
  a_r8_xv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flags_out[FLG_X] == $past(flags_in[FLG_X]) &&
                  flags_out[FLG_V] == $past(flags_in[FLG_V])));

  // R9: vector and advance only accompany a trap
  a_r9_vec_adv: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req ? (trap_vec == VEC_W'(CHK_VEC) && pc_adv != '0)
             : (trap_vec == '0 && pc_adv == '0));

  // R9: advance size depends on the form
  a_r9_adv_form: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && trap_nxt) |=>
      pc_adv == ($past(op_sel) ? ADV_W'(ADV_DUAL) : ADV_W'(ADV_SINGLE)));
endmodule

// File: tb/bnd_trap_unit_bench.sv
`timescale 1ns/1ps
module bnd_trap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_sel;
  logic [31:0] val_in, lo_in, hi_in;
  logic [4:0]  flags_in;
  logic [4:0]  flags_out;
  logic        res_valid, trap_req;
  logic [7:0]  trap_vec;
  logic [2:0]  pc_adv;

  int n_chk  = 0;
  int n_fail = 0;
  logic [4:0] m_flags = 5'd0;   // model of held flags

  always #2.5 clk = ~clk;

  bnd_trap_unit u_bnd_trap_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .val_in(val_in), .lo_in(lo_in), .hi_in(hi_in), .flags_in(flags_in),
    .flags_out(flags_out), .res_valid(res_valid), .trap_req(trap_req),
    .trap_vec(trap_vec), .pc_adv(pc_adv)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock of stimulus plus a comparison against the reference model
  task automatic step(bit v, bit dual, int val, int lo, int hi, bit [4:0] f);
    bit e_trap;
    int e_vec, e_adv;
    @(negedge clk);
    op_valid = v; op_sel = dual; val_in = val; lo_in = lo; hi_in = hi; flags_in = f;
    e_trap = 0; e_vec = 0; e_adv = 0;
    if (v) begin
      m_flags = f;
      if (!dual) begin
        // R2, R3, R4 single form
        m_flags[3] = (val < 0);
        if (hi >= 0) m_flags[0] = !(val >= 0 && val <= hi);
        else         m_flags[0] = (val < 0) && (val > hi);
        e_trap = (val < 0) || (val > hi);
        e_adv  = 2;
      end else begin
        // R5, R6, R7 dual form
        m_flags[2] = (val == lo) || (val == hi);
        if (lo <= hi) m_flags[0] = !(val >= lo && val <= hi);
        else          m_flags[0] = (val < lo) && (val > hi);
        e_trap = m_flags[0];
        e_adv  = 4;
      end
      if (e_trap) e_vec = 6; else e_adv = 0;   // R9
    end
    @(posedge clk); #1;
    check(dual ? "R5/R6/R8 dual flags" : "R2/R3/R8 single flags", flags_out, m_flags);
    check("R1/R10 res_valid", res_valid, v);
    check(dual ? "R7/R10 trap" : "R4/R10 trap", trap_req, e_trap);
    check("R9 vector", trap_vec, e_vec);
    check("R9 pc advance", pc_adv, e_adv);
  endtask

  function automatic int pick();
    int r = $urandom_range(0, 15);
    if (r == 0) return 32'sh7fffffff;
    if (r == 1) return 32'sh80000000;
    return $urandom_range(0, 12) - 6;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b1; op_sel = 1'b1;
    val_in = 32'd5; lo_in = 32'd9; hi_in = 32'd1; flags_in = 5'h1f;
    repeat (3) @(posedge clk);
    #1;
    // R11 outputs stay zero in reset even with a strobe present
    check("R11 reset flags", flags_out, 0);
    check("R11 reset valid", res_valid, 0);
    check("R11 reset trap", trap_req, 0);
    check("R11 reset vector", trap_vec, 0);
    check("R11 reset advance", pc_adv, 0);
    @(negedge clk); rst_n = 1'b1; op_valid = 1'b0;

    // single form, upper limit 10
    step(1, 0, -1, 0, 10, 5'b00000);
    step(1, 0, 0, 0, 10, 5'b11111);
    step(1, 0, 10, 0, 10, 5'b10110);
    step(1, 0, 11, 0, 10, 5'b01000);
    step(1, 0, 0, 0, 0, 5'b01001);
    // single form, negative upper limit: C and trap part ways (R3, R4)
    step(1, 0, -3, 0, -5, 5'b00000);
    step(1, 0, -7, 0, -5, 5'b00010);
    step(1, 0, 4, 0, -5, 5'b11111);
    step(1, 0, 32'sh7fffffff, 0, 32'sh7fffffff, 5'b00000);
    step(1, 0, 32'sh80000000, 0, 32'sh7fffffff, 5'b00100);
    // R10 idle cycles with moving inputs
    step(0, 1, 100, 3, 2, 5'b11111);
    step(0, 0, -9, 0, 4, 5'b00000);
    // dual form, ordered limits
    step(1, 1, -3, -3, 7, 5'b00000);
    step(1, 1, 7, -3, 7, 5'b11011);
    step(1, 1, -4, -3, 7, 5'b00000);
    step(1, 1, 8, -3, 7, 5'b10101);
    step(1, 1, 2, 2, 2, 5'b00001);
    // dual form, swapped limits (R6)
    step(1, 1, 0, 5, -2, 5'b00000);
    step(1, 1, 5, 5, -2, 5'b11111);
    step(1, 1, -5, 5, -2, 5'b00000);
    step(1, 1, -2, 5, -2, 5'b01010);
    step(1, 1, 32'sh80000000, 32'sh7fffffff, 32'sh80000000, 5'b00000);
    step(0, 1, 0, 0, 0, 5'b00000);

    // random run over a small value range
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           pick(), pick(), pick(), 5'($urandom_range(0, 31)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule